// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This block holds the control and status word for a four-lane single-precision SIMD floating-point unit, and decides what happens when an instruction reports exception conditions. Each time an instruction completes, the datapath presents six condition flags per lane. The block combines those flags with its mask bits and with an operating-system enable bit. The result is either a SIMD floating-point exception request or an invalid-opcode request, raised in the same cycle as the completing instruction. Every reported condition is also accumulated into sticky status flags.

Software writes the whole word through a load port and reads it back through a store port. The word also drives the rounding mode used by the datapath. It drives a flush-to-zero command as well, which is only active while underflow is masked. When a flushed underflow occurs, the block records precision loss in addition to underflow.

Top module: `vfp_csr_unit`

## Requirements
- R1: After reset the store port reads 0x0000_1F80. All six mask bits are 1, the flags are 0, the rounding field is 00 and flush-to-zero is 0.
- R2: Word layout. Bits 5:0 hold the status flags in the order invalid, denormal, divide-by-zero, overflow, underflow, precision, starting at bit 0. The mask for flag i sits at bit 7+i. The rounding field is bits 14:13. Flush-to-zero is bit 15. Bit 6 and bits 31:16 always read 0, and writing 1 to them has no effect.
- R3: lane_flags carries six condition bits per lane, lane k at bits 6k+5:6k, in the same order as the status flags. When done_valid is 1, the lanes are ORed together and ORed into the sticky flags. When done_valid is 0, lane_flags is ignored.
- R4: A status flag that is set stays set across idle cycles and later instructions. Only a load that writes 0 to it clears it.
- R5: When sw_load_en is 1, the store port shows the written word (reserved bits cleared) from the next cycle onward. This holds even if done_valid is 1 in the same cycle.
- R6: round_mode equals bits 14:13 of the word: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R7: ftz_cmd is 1 exactly when the flush-to-zero bit is 1 and the underflow mask (bit 11) is 1. While ftz_cmd is 1, a reported underflow also sets the precision flag, and precision then takes part in the exception decision.
- R8: While the underflow mask is 0, the flush-to-zero bit has no effect. ftz_cmd stays 0, and an underflow sets only the underflow flag.
- R9: In a cycle with done_valid=1, if any reported flag has its mask at 0 (using the mask held before any same-cycle load), the block raises an exception request. simd_exc_req is raised when os_exc_en=1, and invop_req is raised when os_exc_en=0. The two requests are never raised together, and neither is raised without done_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_valid | input | 1 | An instruction completes this cycle |
| lane_flags | input | 24 | Per-lane condition flags, six per lane |
| os_exc_en | input | 1 | OS has a SIMD FP exception handler |
| sw_load_en | input | 1 | Software writes the word this cycle |
| sw_load_data | input | 32 | Word written by software |
| sw_store_data | output | 32 | Current word as read by software |
| round_mode | output | 2 | Rounding mode for the datapath |
| ftz_cmd | output | 1 | Flush underflowing results to signed zero |
| simd_exc_req | output | 1 | Raise the SIMD FP exception |
| invop_req | output | 1 | Raise the invalid-opcode exception |

## Verification
The completion path is driven with the following patterns:
- A single flag from one lane, which shows that the lane bit positions are decoded.
- Different flags from several lanes at once, which separates an OR merge from a last-lane-wins merge.
- A completion with flags present but done_valid low, which proves the flags are gated.

Masked and unmasked conditions are run under both OS-enable values, which separates the two request routes. Underflow is tried with flush-to-zero set under a masked and under an unmasked underflow mask. In one case precision is unmasked, so the derived precision flag alone must raise a request. A load coinciding with a completion shows which of the two wins.

// File: rtl/vfp_csr_pkg.sv
package vfp_csr_pkg;

    localparam int LANES    = 4;
    localparam int NFLAG    = 6;
    localparam int CSR_W    = 32;
    localparam int FLAG_LSB = 0;
    localparam int MASK_LSB = 7;
    localparam int RND_LSB  = 13;
    localparam int FTZ_BIT  = 15;

    typedef enum logic [2:0] {
        FL_INV = 3'd0,
        FL_DEN = 3'd1,
        FL_DZ  = 3'd2,
        FL_OVF = 3'd3,
        FL_UNF = 3'd4,
        FL_PRE = 3'd5
    } flag_idx_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic              ftz;
        rnd_mode_e         rnd;
        logic [NFLAG-1:0]  mask;
        logic [NFLAG-1:0]  flags;
    } csr_state_t;

    typedef struct packed {
        logic sx;
        logic io;
    } exc_req_t;

    localparam csr_state_t CSR_RESET = '{
        ftz:   1'b0,
        rnd:   RND_NEAR,
        mask:  {NFLAG{1'b1}},
        flags: {NFLAG{1'b0}}
    };

    function automatic logic [CSR_W-1:0] csr_pack(csr_state_t s);
        logic [CSR_W-1:0] w;
        w = '0;
        w[FLAG_LSB +: NFLAG] = s.flags;
        w[MASK_LSB +: NFLAG] = s.mask;
        w[RND_LSB +: 2]      = s.rnd;
        w[FTZ_BIT]           = s.ftz;
        return w;
    endfunction

endpackage

// File: rtl/vfp_lane_merge.sv
module vfp_lane_merge
    import vfp_csr_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [N_LANES*NFLAG-1:0] lane_flags,
    output logic [NFLAG-1:0]         merged
);

    logic [NFLAG-1:0] acc [0:N_LANES];

    assign acc[0] = '0;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign acc[g+1] = acc[g] | lane_flags[g*NFLAG +: NFLAG];
    end

    assign merged = acc[N_LANES];

endmodule

// File: rtl/vfp_cond_shaper.sv
module vfp_cond_shaper
    import vfp_csr_pkg::*;
(
    input  logic             done_valid,
    input  logic [NFLAG-1:0] merged,
    input  logic             ftz_active,
    output logic [NFLAG-1:0] eff
);

    localparam int UNF_I = int'(FL_UNF);
    localparam int PRE_I = int'(FL_PRE);

    always_comb begin
        eff = done_valid ? merged : '0;
        if (ftz_active && eff[UNF_I]) begin
            eff[PRE_I] = 1'b1;
        end
    end

endmodule

// File: rtl/vfp_exc_decide.sv
module vfp_exc_decide
    import vfp_csr_pkg::*;
(
    input  logic [NFLAG-1:0] eff,
    input  logic [NFLAG-1:0] mask,
    input  logic             os_exc_en,
    output exc_req_t         req
);

    logic [NFLAG-1:0] unmasked;
    logic             hit;

    always_comb begin
        unmasked = eff & ~mask;
        hit      = |unmasked;
        req.sx   = hit &  os_exc_en;
        req.io   = hit & ~os_exc_en;
    end

endmodule

// File: rtl/vfp_csr_regs.sv
module vfp_csr_regs
    import vfp_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  csr_state_t       load_val,
    input  logic             upd_en,
    input  logic [NFLAG-1:0] upd_flags,
    output csr_state_t       state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CSR_RESET;
        end else if (load_en) begin
            state <= load_val;
        end else if (upd_en) begin
            state.flags <= state.flags | upd_flags;
        end
    end

endmodule

// File: rtl/vfp_csr_unit.sv
module vfp_csr_unit
    import vfp_csr_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     done_valid,
    input  logic [N_LANES*NFLAG-1:0] lane_flags,
    input  logic                     os_exc_en,
    input  logic                     sw_load_en,
    input  logic [CSR_W-1:0]         sw_load_data,
    output logic [CSR_W-1:0]         sw_store_data,
    output logic [1:0]               round_mode,
    output logic                     ftz_cmd,
    output logic                     simd_exc_req,
    output logic                     invop_req
);

    csr_state_t       state;
    csr_state_t       load_val;
    logic [NFLAG-1:0] merged;
    logic [NFLAG-1:0] eff;
    logic             ftz_active;
    exc_req_t         req;
    logic             unused_rsvd;

    // Only defined fields are captured; reserved bits are dropped here.
    always_comb begin
        load_val.flags = sw_load_data[FLAG_LSB +: NFLAG];
        load_val.mask  = sw_load_data[MASK_LSB +: NFLAG];
        load_val.rnd   = rnd_mode_e'(sw_load_data[RND_LSB +: 2]);
        load_val.ftz   = sw_load_data[FTZ_BIT];
    end

    assign unused_rsvd = ^{sw_load_data[CSR_W-1:FTZ_BIT+1], sw_load_data[NFLAG]};

    assign ftz_active = state.ftz & state.mask[int'(FL_UNF)];

    vfp_lane_merge #(.N_LANES(N_LANES)) u_merge (
        .lane_flags (lane_flags),
        .merged     (merged)
    );

    vfp_cond_shaper u_shape (
        .done_valid (done_valid),
        .merged     (merged),
        .ftz_active (ftz_active),
        .eff        (eff)
    );

    vfp_exc_decide u_decide (
        .eff       (eff),
        .mask      (state.mask),
        .os_exc_en (os_exc_en),
        .req       (req)
    );

    vfp_csr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_en   (sw_load_en),
        .load_val  (load_val),
        .upd_en    (done_valid),
        .upd_flags (eff),
        .state     (state)
    );

    assign sw_store_data = csr_pack(state);
    assign round_mode    = state.rnd;
    assign ftz_cmd       = ftz_active;
    assign simd_exc_req  = req.sx;
    assign invop_req     = req.io;

endmodule

// File: rtl/vfp_csr_checks.sv
module vfp_csr_checks
    import vfp_csr_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     done_valid,
    input logic [N_LANES*NFLAG-1:0] lane_flags,
    input logic                     os_exc_en,
    input logic                     sw_load_en,
    input logic [CSR_W-1:0]         sw_load_data,
    input logic [CSR_W-1:0]         sw_store_data,
    input logic                     ftz_cmd,
    input logic                     simd_exc_req,
    input logic                     invop_req
);

    localparam logic [CSR_W-1:0] WR_MASK =
          (CSR_W'((1 << NFLAG) - 1) << FLAG_LSB)
        | (CSR_W'((1 << NFLAG) - 1) << MASK_LSB)
        | (CSR_W'(3) << RND_LSB)
        | (CSR_W'(1) << FTZ_BIT);

    localparam int UNF_I = int'(FL_UNF);
    localparam int PRE_I = int'(FL_PRE);

    logic any_unf;
    always_comb begin
        any_unf = 1'b0;
        for (int k = 0; k < N_LANES; k++) begin
            any_unf = any_unf | lane_flags[k*NFLAG + UNF_I];
        end
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (sw_store_data & ~WR_MASK) == '0);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !sw_load_en |=> ((sw_store_data[NFLAG-1:0] & $past(sw_store_data[NFLAG-1:0]))
                         == $past(sw_store_data[NFLAG-1:0])));

    assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
        sw_load_en |=> (sw_store_data == ($past(sw_load_data) & WR_MASK)));

    assert_ftz_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (done_valid && ftz_cmd && any_unf && !sw_load_en)
        |=> (sw_store_data[UNF_I] && sw_store_data[PRE_I]));

    assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(simd_exc_req && invop_req));

    assert_req_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
        !done_valid |-> (!simd_exc_req && !invop_req));

    assert_os_route_R9: assert property (@(posedge clk) disable iff (rst)
        os_exc_en |-> !invop_req);

endmodule

bind vfp_csr_unit vfp_csr_checks #(.N_LANES(N_LANES)) u_chk (.*);

// File: tb/vfp_csr_unit_tb.sv
module vfp_csr_unit_tb;

    localparam int NL = 4;
    localparam int NF = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          done_valid = 1'b0;
    logic [NL*NF-1:0] lane_flags = '0;
    logic          os_exc_en = 1'b0;
    logic          sw_load_en = 1'b0;
    logic [31:0]   sw_load_data = '0;
    logic [31:0]   sw_store_data;
    logic [1:0]    round_mode;
    logic          ftz_cmd;
    logic          simd_exc_req;
    logic          invop_req;

    always #4 clk = ~clk;

    vfp_csr_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .done_valid    (done_valid),
        .lane_flags    (lane_flags),
        .os_exc_en     (os_exc_en),
        .sw_load_en    (sw_load_en),
        .sw_load_data  (sw_load_data),
        .sw_store_data (sw_store_data),
        .round_mode    (round_mode),
        .ftz_cmd       (ftz_cmd),
        .simd_exc_req  (simd_exc_req),
        .invop_req     (invop_req)
    );

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic [1:0]  rm;
        logic        ftz;
        logic        sx;
        logic        io;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] m_csr    = 32'h0000_1F80;
    bit          finished = 1'b0;

    task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic step(string tag, bit done, logic [NL*NF-1:0] lanes,
                        bit ld, logic [31:0] ldw, bit os);
        logic [NF-1:0] mrg;
        logic [NF-1:0] eff;
        logic [NF-1:0] unm;
        logic          ftz_on;
        exp_t          e;
        @(negedge clk);
        done_valid   = done;
        lane_flags   = lanes;
        sw_load_en   = ld;
        sw_load_data = ldw;
        os_exc_en    = os;
        mrg = '0;
        for (int l = 0; l < NL; l++) mrg = mrg | lanes[l*NF +: NF];
        ftz_on = m_csr[15] & m_csr[11];
        eff = done ? mrg : '0;
        if (ftz_on && eff[4]) eff[5] = 1'b1;
        unm = eff & ~m_csr[12:7];
        e.tag = tag;
        e.rd  = m_csr;
        e.rm  = m_csr[14:13];
        e.ftz = ftz_on;
        e.sx  = (|unm) & os;
        e.io  = (|unm) & ~os;
        sb.push_back(e);
        if (ld) m_csr = ldw & 32'h0000_FFBF;
        else    m_csr[5:0] = m_csr[5:0] | eff;
    endtask

    // Monitor: samples late in each cycle, away from the rising edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                cmp(e.tag, "store", sw_store_data, e.rd);
                cmp(e.tag, "round", {30'd0, round_mode}, {30'd0, e.rm});
                cmp(e.tag, "ftz",   {31'd0, ftz_cmd}, {31'd0, e.ftz});
                cmp(e.tag, "simd",  {31'd0, simd_exc_req}, {31'd0, e.sx});
                cmp(e.tag, "invop", {31'd0, invop_req}, {31'd0, e.io});
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        step("R1 reset value",           0, '0, 0, '0, 0);
        step("R3 done no flags",         1, '0, 0, '0, 0);
        step("R3 lane2 overflow masked", 1, 24'(1) << (12 + 3), 0, '0, 0);
        step("R4 overflow held",         0, '0, 0, '0, 0);
        step("R3 flags without done",    0, 24'hFFFFFF, 0, '0, 1);
        step("R5 R6 load rc down",       0, '0, 1, (32'h1F80 & ~(32'h1 << 9)) | (32'h1 << 13) | 32'h08, 1);
        step("R9 simd request",          1, 24'(1) << (6 + 2), 0, '0, 1);
        step("R9 invop request",         1, 24'(1) << (18 + 2), 0, '0, 0);
        step("R6 load rc up",            0, '0, 1, 32'h1F80 | (32'h2 << 13), 0);
        step("R2 R6 rc zero reserved",   0, '0, 1, 32'hFFFF_0040 | 32'h1F80 | (32'h3 << 13) | (32'h1 << 15), 0);
        step("R7 ftz underflow",         1, 24'(1) << 4, 0, '0, 1);
        step("R7 unmask precision",      0, '0, 1, (32'h1F80 & ~(32'h1 << 12)) | (32'h1 << 15), 1);
        step("R7 derived precision req", 1, 24'(1) << (6 + 4), 0, '0, 1);
        step("R8 unmask underflow",      0, '0, 1, (32'h1F80 & ~(32'h1 << 11)) | (32'h1 << 15), 1);
        step("R8 underflow no flush",    1, 24'(1) << (18 + 4), 0, '0, 1);
        step("R5 load beats update",     1, 24'hFFFFFF & ~(24'h410410), 1, 32'h1F80, 1);
        step("R3 multi lane merge",      1, (24'(1) << 0) | (24'(1) << (6 + 1)) | (24'(1) << (18 + 5)), 0, '0, 0);
        step("R4 multi flags held",      0, '0, 0, '0, 0);
        step("R4 clear by load",         0, '0, 1, 32'h1F80 | 32'h20, 0);
        step("R4 after clear",           1, '0, 0, '0, 1);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule